// File: doc/BRIEF.md
# Per-Pin GPIO Output Data Bank

This block holds one output data register for every general-purpose pin and one pad configuration register that chooses what the pin does. Software reaches both through a byte-wide register bus: a byte address, a write strobe, write data and combinational read data. Each pin's data register keeps a single bit. That bit reaches the pad only while the pin's configuration selects the output function. While the pin is configured as an input, writes to its data register are dropped.

A value can be written while the pin has no function assigned and read back at any time. Because of this, software can preload the level and then switch the pin to output. The preloaded level appears on the pad on the same clock edge that the configuration changes, with no further data write. The register bus carries single-cycle control accesses and has no back-pressure, so it stays a plain strobe interface and not a valid/ready stream. The pad-side outputs are plain level signals.

Top module: `gpio_out_bank`

## Requirements
- R1: Pin n's data register sits at byte address DAT_BASE + n (default 0x600). Bit 0 holds the data. Bits 7:1 always read as zero, and writes to them are dropped.
- R2: Pin n's 16-bit pad configuration occupies address 2n (upper byte) and 2n+1 (lower byte). The function field is lower-byte bits 1:0, with the codes 00 = none, 01 = output, 10 and 11 = input. The drive field is upper-byte bits 1:0, is stored and read back, and has no effect on the pins. All other bits read as zero.
- R3: A write to a data register is dropped while that pin's function field is 10 or 11. It is accepted while the field is 00 or 01.
- R4: pin_oe[n] is high exactly when pin n's function field is 01. pin_out[n] equals the stored data bit while pin_oe[n] is high, and is 0 otherwise.
- R5: When a configuration write changes a pin to output, the stored data bit appears on pin_out on that same clock edge, with no data write.
- R6: While rst_n is low, every data and configuration register resets to zero, so every pin has no function and both pin_oe and pin_out are low.
- R7: A read of a data register returns the stored bit whatever the pin's function, including while writes to it are blocked.
- R8: An address outside both register ranges (at or above 2·NUM_PINS in the configuration range, at or above DAT_BASE + NUM_PINS in the data range) reads as zero, and a write to it changes no register.
- R9: A write takes effect on the rising clock edge where bus_we is sampled high. bus_rdata is combinational, so a read of the register being written shows the old value in that same cycle and the new value after the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pin_out | output | NUM_PINS | Pad output level per pin |
| pin_oe | output | NUM_PINS | Pad output enable per pin |

## Verification
Two events can meet in one cycle. The first is a bus write that lands on a pin's register while that same register is being read. The second is a configuration write that turns a pin on as an output while the data bit waiting for it is read back. The bench writes data into a pin that has no function and into pins configured as input, and then switches each pin to output. It checks that pin_out shows the earlier accepted value on the first sample after the configuration edge. A separate directed step holds a write to a data register and checks bus_rdata before the edge (old value) and after it (new value).

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  // Function codes held in the low two bits of a pad configuration
  typedef enum logic [1:0] {
    FN_NONE = 2'b00,
    FN_OUT  = 2'b01,
    FN_IN_A = 2'b10,
    FN_IN_B = 2'b11
  } pad_fn_e;

  // Both input codes share the upper bit
  function automatic logic fn_is_input(pad_fn_e f);
    return f[1];
  endfunction

endpackage

// File: rtl/gpio_bank_dec.sv
// Address decoder: one-hot hit vectors for the three byte lanes of each pin
module gpio_bank_dec #(
  parameter int                NUM_PINS = 16,
  parameter int                ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] DAT_BASE = 'h600
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic [NUM_PINS-1:0] cfg_hi_hit,
  output logic [NUM_PINS-1:0] cfg_lo_hit,
  output logic [NUM_PINS-1:0] dat_hit
);

  always_comb begin
    for (int i = 0; i < NUM_PINS; i++) begin
      cfg_hi_hit[i] = (addr == ADDR_W'(2 * i));
      cfg_lo_hit[i] = (addr == ADDR_W'(2 * i + 1));
      dat_hit[i]    = (addr == DAT_BASE + ADDR_W'(i));
    end
  end

endmodule

// File: rtl/gpio_pad_cfg.sv
// One pad configuration: function field and stored drive field
module gpio_pad_cfg
  import gpio_bank_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_hi,
  input  logic       wr_lo,
  input  logic [1:0] wbits,
  output pad_fn_e    fn,
  output logic [1:0] drv
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fn  <= FN_NONE;
      drv <= 2'b00;
    end else begin
      if (wr_lo) fn  <= pad_fn_e'(wbits);
      if (wr_hi) drv <= wbits;
    end
  end

endmodule

// File: rtl/gpio_dout_cell.sv
// One output data bit, write-gated by pad direction, driving the pad
module gpio_dout_cell
  import gpio_bank_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    wr,
  input  logic    wbit,
  input  pad_fn_e fn,
  output logic    dat_q,
  output logic    pad_out,
  output logic    pad_oe
);

  always_ff @(posedge clk) begin
    if (!rst_n)
      dat_q <= 1'b0;
    else if (wr && !fn_is_input(fn))
      dat_q <= wbit;
  end

  // Driven straight from the stored bit: turning output on needs no data write
  assign pad_oe  = (fn == FN_OUT);
  assign pad_out = pad_oe & dat_q;

endmodule

// File: rtl/gpio_out_bank.sv
module gpio_out_bank
  import gpio_bank_pkg::*;
#(
  parameter int                NUM_PINS = 16,
  parameter int                ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] DAT_BASE = 'h600
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [7:0]          bus_wdata,
  output logic [7:0]          bus_rdata,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe
);

  logic [NUM_PINS-1:0]   cfg_hi_hit, cfg_lo_hit, dat_hit;
  logic [NUM_PINS-1:0]   dat_flat;
  logic [2*NUM_PINS-1:0] fn_flat;
  logic [2*NUM_PINS-1:0] drv_flat;
  logic                  unused_wbits;

  assign unused_wbits = ^bus_wdata[7:2];

  gpio_bank_dec #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W),
    .DAT_BASE (DAT_BASE)
  ) u_dec (
    .addr       (bus_addr),
    .cfg_hi_hit (cfg_hi_hit),
    .cfg_lo_hit (cfg_lo_hit),
    .dat_hit    (dat_hit)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    pad_fn_e fn_w;

    gpio_pad_cfg u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_hi (bus_we & cfg_hi_hit[g]),
      .wr_lo (bus_we & cfg_lo_hit[g]),
      .wbits (bus_wdata[1:0]),
      .fn    (fn_w),
      .drv   (drv_flat[2*g +: 2])
    );

    gpio_dout_cell u_dout (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (bus_we & dat_hit[g]),
      .wbit    (bus_wdata[0]),
      .fn      (fn_w),
      .dat_q   (dat_flat[g]),
      .pad_out (pin_out[g]),
      .pad_oe  (pin_oe[g])
    );

    assign fn_flat[2*g +: 2] = fn_w;
  end

  // Read mux: hits are one-hot, so OR-reduction; no hit reads zero
  always_comb begin
    bus_rdata = 8'h00;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (cfg_hi_hit[i]) bus_rdata = bus_rdata | {6'b0, drv_flat[2*i +: 2]};
      if (cfg_lo_hit[i]) bus_rdata = bus_rdata | {6'b0, fn_flat[2*i +: 2]};
      if (dat_hit[i])    bus_rdata = bus_rdata | {7'b0, dat_flat[i]};
    end
  end

endmodule

// File: rtl/gpio_out_bank_chk.sv
module gpio_out_bank_chk #(
  parameter int                NUM_PINS = 16,
  parameter int                ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] DAT_BASE = 'h600
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic                  bus_we,
  input logic [7:0]            bus_rdata,
  input logic [NUM_PINS-1:0]   pin_out,
  input logic [NUM_PINS-1:0]   pin_oe,
  input logic [NUM_PINS-1:0]   dat_flat,
  input logic [2*NUM_PINS-1:0] fn_flat
);

  localparam logic [ADDR_W-1:0] CFG_END = ADDR_W'(2 * NUM_PINS);
  localparam logic [ADDR_W-1:0] DAT_END = DAT_BASE + ADDR_W'(NUM_PINS);

  logic addr_void;
  assign addr_void = (bus_addr >= CFG_END) &&
                     !((bus_addr >= DAT_BASE) && (bus_addr < DAT_END));

  assert_void_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    addr_void |-> (bus_rdata == 8'h00));

  assert_void_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && addr_void) |=> ($stable(dat_flat) && $stable(fn_flat)));

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin_chk
    assert_blocked_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == DAT_BASE + ADDR_W'(g) && fn_flat[2*g+1])
        |=> $stable(dat_flat[g]));

    assert_turn_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pin_oe[g]) |-> (pin_out[g] == $past(dat_flat[g])));

    assert_idle_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_oe[g] |-> !pin_out[g]);

    assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == DAT_BASE + ADDR_W'(g)) |-> (bus_rdata[7:1] == 7'h00));
  end

endmodule

bind gpio_out_bank gpio_out_bank_chk #(
  .NUM_PINS (NUM_PINS),
  .ADDR_W   (ADDR_W),
  .DAT_BASE (DAT_BASE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .dat_flat  (dat_flat),
  .fn_flat   (fn_flat)
);

// File: tb/tb_gpio_out_bank.sv
`timescale 1ns/1ps
module tb_gpio_out_bank;

  localparam int N  = 16;
  localparam int AW = 12;

  typedef struct packed {
    logic        we;
    logic [11:0] addr;
    logic [7:0]  wdata;
    logic [7:0]  exp_rd;
    logic [3:0]  exp_oe;
    logic [3:0]  exp_out;
    logic [3:0]  req;
  } vec_t;

  // Each step: optional write, then read-back of the same address plus pads 3:0
  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 12'h600, 8'hFF, 8'h01, 4'b0000, 4'b0000, 4'd1}, // R1 R3 write accepted, no function
    '{1'b1, 12'h001, 8'h01, 8'h01, 4'b0001, 4'b0001, 4'd5}, // R5 pin0 to output shows preload
    '{1'b1, 12'h601, 8'h01, 8'h01, 4'b0001, 4'b0001, 4'd3}, // R3 pin1 no function, accepted
    '{1'b1, 12'h003, 8'h02, 8'h02, 4'b0001, 4'b0001, 4'd2}, // R2 pin1 input code 10
    '{1'b1, 12'h601, 8'h00, 8'h01, 4'b0001, 4'b0001, 4'd3}, // R3 R7 write blocked, read still 1
    '{1'b1, 12'h003, 8'h03, 8'h03, 4'b0001, 4'b0001, 4'd2}, // R2 input code 11
    '{1'b1, 12'h601, 8'h00, 8'h01, 4'b0001, 4'b0001, 4'd3}, // R3 blocked under code 11
    '{1'b1, 12'h003, 8'h01, 8'h01, 4'b0011, 4'b0011, 4'd5}, // R5 pin1 input->output
    '{1'b1, 12'h601, 8'h00, 8'h00, 4'b0011, 4'b0001, 4'd4}, // R4 output follows data
    '{1'b1, 12'h002, 8'hFF, 8'h03, 4'b0011, 4'b0001, 4'd2}, // R2 drive field only 1:0
    '{1'b0, 12'h003, 8'h00, 8'h01, 4'b0011, 4'b0001, 4'd2}, // R2 function read-back
    '{1'b1, 12'h001, 8'h00, 8'h00, 4'b0010, 4'b0000, 4'd4}, // R4 pin0 off, pad low
    '{1'b0, 12'h600, 8'h00, 8'h01, 4'b0010, 4'b0000, 4'd7}, // R7 stored bit kept
    '{1'b1, 12'h610, 8'h01, 8'h00, 4'b0010, 4'b0000, 4'd8}, // R8 data past last pin
    '{1'b1, 12'h020, 8'h03, 8'h00, 4'b0010, 4'b0000, 4'd8}, // R8 config past last pin
    '{1'b1, 12'h021, 8'h01, 8'h00, 4'b0010, 4'b0000, 4'd8}, // R8
    '{1'b0, 12'hFFF, 8'h00, 8'h00, 4'b0010, 4'b0000, 4'd8}, // R8 top of space
    '{1'b1, 12'h60F, 8'h01, 8'h01, 4'b0010, 4'b0000, 4'd1}, // R1 last pin data
    '{1'b1, 12'h01F, 8'h01, 8'h01, 4'b0010, 4'b0000, 4'd5}, // R5 last pin on
    '{1'b1, 12'h605, 8'hFE, 8'h00, 4'b0010, 4'b0000, 4'd1}  // R1 upper bits dropped
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] bus_addr;
  logic          bus_we;
  logic [7:0]    bus_wdata;
  logic [7:0]    bus_rdata;
  logic [N-1:0]  pin_out;
  logic [N-1:0]  pin_oe;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  gpio_out_bank #(.NUM_PINS(N), .ADDR_W(AW), .DAT_BASE(12'h600)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R6: reset state
    check("R6 pin_oe after reset", pin_oe, '0);
    check("R6 pin_out after reset", pin_out, '0);
    bus_addr = 12'h001; #1;
    check("R6 function reads zero", bus_rdata, 8'h00);
    bus_addr = 12'h600; #1;
    check("R6 data reads zero", bus_rdata, 8'h00);

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      bus_we = VEC[k].we; bus_addr = VEC[k].addr; bus_wdata = VEC[k].wdata;
      @(negedge clk);
      bus_we = 1'b0;
      #1;
      check($sformatf("R%0d vector %0d rdata", VEC[k].req, k), bus_rdata, VEC[k].exp_rd);
      check($sformatf("R%0d vector %0d oe", VEC[k].req, k), pin_oe[3:0], VEC[k].exp_oe);
      check($sformatf("R%0d vector %0d out", VEC[k].req, k), pin_out[3:0], VEC[k].exp_out);
    end
    check("R5 last pin enabled", pin_oe[N-1], 1'b1);
    check("R5 last pin level", pin_out[N-1], 1'b1);

    // R9: same-cycle read while writing pin2 data
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 12'h602; bus_wdata = 8'h01;
    #1;
    check("R9 old value before edge", bus_rdata, 8'h00);
    @(negedge clk);
    bus_we = 1'b0;
    #1;
    check("R9 new value after edge", bus_rdata, 8'h01);
    // R5: pin2 turned on drives preloaded 1
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 12'h005; bus_wdata = 8'h01;
    @(negedge clk);
    bus_we = 1'b0; #1;
    check("R5 pin2 preload driven", pin_out[2], 1'b1);
    check("R4 pin2 enabled", pin_oe[2], 1'b1);

    // R6: reset mid-run clears everything
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1; #1;
    check("R6 oe cleared", pin_oe, '0);
    check("R6 out cleared", pin_out, '0);
    bus_addr = 12'h602; #1;
    check("R6 data cleared", bus_rdata, 8'h00);
    bus_addr = 12'h002; #1;
    check("R6 drive cleared", bus_rdata, 8'h00);

    finish_run();
  end

endmodule